// File: doc/BRIEF.md
# Horizontal Line Timing and Clamp Generator

This block derives all horizontal timing for one LCD panel line from a dot clock. A programmable dot counter sets the line length. Once per line it emits a one-dot pulse, in both polarities, that an external phase-locked loop compares against incoming horizontal sync.

The same count places a 644-dot display window behind a programmable offset. It also places two active-low clamp pulses that share a common centre. A two-bit selector moves both clamp pulses in 7-dot steps.

A mode input chooses between a VGA line, whose length comes from the divider input, and a TV line of fixed length. Divider, offset, clamp selection and mode are all captured at the start of each line. A host can therefore rewrite them at any time without producing a short or broken line.

Top module: `htg_line_timer`

## Requirements
- R1: In VGA mode (mode input high) each line lasts the 11-bit divider value plus one dots, for example 799 gives 800 dots and 1023 gives 1024.
- R2: In TV mode (mode input low) each line lasts 816 dots whatever the divider input holds.
- R3: The comparison pulse is high for exactly the first dot of every line and low elsewhere; its complement output is always its inverse.
- R4: The window start marker is high for one dot, at dot index base plus the 7-bit offset, with base 110 in VGA mode and 75 in TV mode (dot 0 being the dot where the comparison pulse is high).
- R5: The active-window flag is high from the start dot for 644 dots, ending earlier if the line ends first.
- R6: XCLP1 (active low) is low for 40 dots starting at dot 74 + 7*s, where s is the 2-bit clamp select value 0 to 3.
- R7: XCLP2 (active low) is low for 67 dots starting at dot 61 + 7*s, so it spans XCLP1 with the same centre to within half a dot.
- R8: Divider, offset, clamp select and mode are sampled only at the line boundary; a change during a line leaves that line unchanged and takes effect on the next.
- R9: While reset is asserted the comparison pulse, start marker and window flag are low and the complement and both clamp outputs are high; the first line after reset runs with TV length (816), offset 0, clamp select 0 and TV base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_last_i | input | 11 | Line length minus one, used in VGA mode |
| hpos_i | input | 7 | Display window offset in dots above the mode base |
| clp_sel_i | input | 2 | Clamp position select |
| vga_mode_i | input | 1 | High selects VGA timing, low selects TV timing |
| cmp_o | output | 1 | Phase comparison pulse, active high |
| cmp_n_o | output | 1 | Phase comparison pulse, active low |
| win_start_o | output | 1 | One-dot display window start marker |
| win_active_o | output | 1 | Display window active flag |
| xclp1_n_o | output | 1 | Narrow clamp pulse, active low |
| xclp2_n_o | output | 1 | Wide clamp pulse, active low |

## Verification
A corrupted dot count or captured line length shows up at once as a comparison pulse spacing that differs from the expected line length, within one line. Wrong captured offset or clamp select moves the start marker, window edges or clamp edges by whole dots on the very next line. A capture enable that fires mid-line is exposed when a setting is changed part way through a line and the edges of that same line shift. Each line is compared dot by dot against positions derived from the requirements.

// File: rtl/htg_pkg.sv
package htg_pkg;

  typedef enum logic {
    MODE_TV  = 1'b0,
    MODE_VGA = 1'b1
  } mode_e;

  // fixed TV line: 816 dots
  localparam int unsigned TV_LAST    = 815;
  localparam int unsigned HBASE_VGA  = 110;
  localparam int unsigned HBASE_TV   = 75;
  localparam int unsigned WIN_DOTS   = 644;
  localparam int unsigned CLP_STEP   = 7;
  localparam int unsigned CLP_NUM    = 2;
  // index 0: narrow clamp, index 1: wide clamp
  localparam int unsigned CLP_FIRST [CLP_NUM] = '{74, 61};
  localparam int unsigned CLP_LEN   [CLP_NUM] = '{40, 67};

endpackage

// File: rtl/htg_rst_sync.sv
module htg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/htg_dot_counter.sv
module htg_dot_counter
  import htg_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] last_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             wrap;

  assign wrap = (cnt_q == last_q);

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + CNT_W'(1);
    last_d = last_q;
    if (wrap) begin
      last_d = last_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= CNT_W'(TV_LAST);
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = last_q;
  assign wrap_o = wrap;

endmodule

// File: rtl/htg_cfg_shadow.sv
module htg_cfg_shadow
  import htg_pkg::*;
#(
  parameter int unsigned POS_W = 7,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  mode_e            mode_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [SEL_W-1:0] sel_i,
  output mode_e            mode_o,
  output logic [POS_W-1:0] pos_o,
  output logic [SEL_W-1:0] sel_o
);

  mode_e            mode_q, mode_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    mode_d = mode_q;
    pos_d  = pos_q;
    sel_d  = sel_q;
    if (load_i) begin
      mode_d = mode_i;
      pos_d  = pos_i;
      sel_d  = sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_TV;
      pos_q  <= '0;
      sel_q  <= '0;
    end else begin
      mode_q <= mode_d;
      pos_q  <= pos_d;
      sel_q  <= sel_d;
    end
  end

  assign mode_o = mode_q;
  assign pos_o  = pos_q;
  assign sel_o  = sel_q;

endmodule

// File: rtl/htg_span_gen.sv
module htg_span_gen #(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned EXT_W   = 13,
  parameter int unsigned LEN     = 40,
  parameter bit          ACT_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [EXT_W-1:0] first_i,
  output logic             lvl_o
);

  logic [EXT_W-1:0] cnt_x;
  logic             hit;
  logic             lvl_q, lvl_d;

  always_comb begin
    cnt_x = EXT_W'(cnt_i);
    hit   = (cnt_x >= first_i) && (cnt_x < first_i + EXT_W'(LEN));
    lvl_d = hit ^ ACT_LOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= ACT_LOW;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/htg_line_timer.sv
module htg_line_timer
  import htg_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned POS_W = 7,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] div_last_i,
  input  logic [POS_W-1:0] hpos_i,
  input  logic [SEL_W-1:0] clp_sel_i,
  input  logic             vga_mode_i,
  output logic             cmp_o,
  output logic             cmp_n_o,
  output logic             win_start_o,
  output logic             win_active_o,
  output logic             xclp1_n_o,
  output logic             xclp2_n_o
);

  localparam int unsigned EXT_W = CNT_W + 2;

  logic             rst_sync_n;
  logic [CNT_W-1:0] dot_cnt;
  logic [CNT_W-1:0] dot_last;
  logic [CNT_W-1:0] next_last;
  logic             line_wrap;
  mode_e            mode_in;
  mode_e            line_mode;
  logic [POS_W-1:0] pos_q;
  logic [SEL_W-1:0] sel_q;
  logic [EXT_W-1:0] win_first;
  logic [CLP_NUM-1:0] clp_n;

  logic cmp_q, cmp_d;
  logic cmp_n_q, cmp_n_d;
  logic start_q, start_d;

  htg_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign mode_in   = vga_mode_i ? MODE_VGA : MODE_TV;
  assign next_last = vga_mode_i ? div_last_i : CNT_W'(TV_LAST);

  htg_dot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .last_i (next_last),
    .cnt_o  (dot_cnt),
    .last_o (dot_last),
    .wrap_o (line_wrap)
  );

  htg_cfg_shadow #(.POS_W(POS_W), .SEL_W(SEL_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .load_i (line_wrap),
    .mode_i (mode_in),
    .pos_i  (hpos_i),
    .sel_i  (clp_sel_i),
    .mode_o (line_mode),
    .pos_o  (pos_q),
    .sel_o  (sel_q)
  );

  assign win_first = ((line_mode == MODE_VGA) ? EXT_W'(HBASE_VGA) : EXT_W'(HBASE_TV))
                   + EXT_W'(pos_q);

  // line-start and window-start markers
  always_comb begin
    cmp_d   = (dot_cnt == '0);
    cmp_n_d = (dot_cnt != '0);
    start_d = (EXT_W'(dot_cnt) == win_first);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmp_q   <= 1'b0;
      cmp_n_q <= 1'b1;
      start_q <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      cmp_n_q <= cmp_n_d;
      start_q <= start_d;
    end
  end

  htg_span_gen #(
    .CNT_W(CNT_W), .EXT_W(EXT_W), .LEN(WIN_DOTS), .ACT_LOW(1'b0)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .cnt_i   (dot_cnt),
    .first_i (win_first),
    .lvl_o   (win_active_o)
  );

  for (genvar g = 0; g < CLP_NUM; g++) begin : g_clp
    logic [EXT_W-1:0] clp_first;
    assign clp_first = EXT_W'(CLP_FIRST[g]) + EXT_W'(CLP_STEP) * EXT_W'(sel_q);

    htg_span_gen #(
      .CNT_W(CNT_W), .EXT_W(EXT_W), .LEN(CLP_LEN[g]), .ACT_LOW(1'b1)
    ) u_clp (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .cnt_i   (dot_cnt),
      .first_i (clp_first),
      .lvl_o   (clp_n[g])
    );
  end

  assign cmp_o       = cmp_q;
  assign cmp_n_o     = cmp_n_q;
  assign win_start_o = start_q;
  assign xclp1_n_o   = clp_n[0];
  assign xclp2_n_o   = clp_n[1];

endmodule

// File: rtl/htg_line_timer_chk.sv
module htg_line_timer_chk
  import htg_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] dot_cnt,
  input logic [CNT_W-1:0] dot_last,
  input mode_e            line_mode,
  input logic             cmp_o,
  input logic             win_start_o,
  input logic             win_active_o,
  input logic             xclp1_n_o,
  input logic             xclp2_n_o
);

  // R1: counter never passes the captured last dot
  a_r1_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_cnt <= dot_last);

  // R2: a TV line always carries the fixed length
  a_r2_tv_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_mode == MODE_TV) |-> (dot_last == CNT_W'(TV_LAST)));

  // R8: captured length only moves at the line boundary
  a_r8_last_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_cnt != '0) |-> $stable(dot_last));

  // R3: comparison pulse appears right after dot 0 and lasts one dot
  a_r3_cmp_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_cnt == CNT_W'(1)) |-> cmp_o);

  a_r3_cmp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_o |=> !cmp_o);

  // R4: start marker lies inside the window
  a_r4_start_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_start_o |-> win_active_o);

  // R5: window opens only at the start marker
  a_r5_open_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_active_o) |-> win_start_o);

  // R6 / R7: narrow clamp nested in wide clamp
  a_r6_clp1_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xclp1_n_o |-> !xclp2_n_o);

endmodule

bind htg_line_timer htg_line_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_sync_n),
  .dot_cnt      (dot_cnt),
  .dot_last     (dot_last),
  .line_mode    (line_mode),
  .cmp_o        (cmp_o),
  .win_start_o  (win_start_o),
  .win_active_o (win_active_o),
  .xclp1_n_o    (xclp1_n_o),
  .xclp2_n_o    (xclp2_n_o)
);

// File: tb/tb_htg_line_timer.sv
module tb_htg_line_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] div_last;
  logic [6:0]  hpos;
  logic [1:0]  sel;
  logic        vga;
  logic        cmp, cmp_n, wstart, wact, clp1_n, clp2_n;

  always #10 clk = ~clk;

  htg_line_timer dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .div_last_i   (div_last),
    .hpos_i       (hpos),
    .clp_sel_i    (sel),
    .vga_mode_i   (vga),
    .cmp_o        (cmp),
    .cmp_n_o      (cmp_n),
    .win_start_o  (wstart),
    .win_active_o (wact),
    .xclp1_n_o    (clp1_n),
    .xclp2_n_o    (clp2_n)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // pending mid-line change
  int          chg_at = -1;
  logic [10:0] n_div;
  logic [6:0]  n_pos;
  logic [1:0]  n_sel;
  logic        n_vga;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic set_cfg(logic v, logic [10:0] d, logic [6:0] p, logic [1:0] s);
    vga = v; div_last = d; hpos = p; sel = s;
  endtask

  task automatic skip_line();
    do @(negedge clk); while (cmp !== 1'b1);
  endtask

  // measure one whole line dot by dot; dot 0 is where cmp is high
  task automatic measure_line(int exp_len, int exp_start, int exp_sel, string len_req);
    string req  [5] = '{"R3", "R4", "R5", "R6", "R7"};
    string name [5] = '{"cmp pair", "start marker", "window flag", "xclp1", "xclp2"};
    int bad_k [5] = '{-1, -1, -1, -1, -1};
    int bad_a [5];
    int bad_e [5];
    int act [5];
    int exp [5];
    int k;
    skip_line();
    k = 0;
    forever begin
      act[0] = int'(cmp) + 2 * int'(cmp_n);
      exp[0] = (k == 0) ? 1 : 2;
      act[1] = int'(wstart);
      exp[1] = (k == exp_start) ? 1 : 0;
      act[2] = int'(wact);
      exp[2] = (k >= exp_start && k < exp_start + 644) ? 1 : 0;
      act[3] = int'(clp1_n);
      exp[3] = (k >= 74 + 7 * exp_sel && k < 114 + 7 * exp_sel) ? 0 : 1;
      act[4] = int'(clp2_n);
      exp[4] = (k >= 61 + 7 * exp_sel && k < 128 + 7 * exp_sel) ? 0 : 1;
      for (int i = 0; i < 5; i++) begin
        if (bad_k[i] < 0 && act[i] != exp[i]) begin
          bad_k[i] = k; bad_a[i] = act[i]; bad_e[i] = exp[i];
        end
      end
      if (k == chg_at) begin
        set_cfg(n_vga, n_div, n_pos, n_sel);
        chg_at = -1;
      end
      k++;
      @(negedge clk);
      if (cmp === 1'b1 || k > 4096) break;
    end
    check(k == exp_len, len_req, "line length", k, exp_len);
    for (int i = 0; i < 5; i++) begin
      check(bad_k[i] < 0, req[i], $sformatf("%s at dot %0d", name[i], bad_k[i]),
            bad_a[i], bad_e[i]);
    end
  endtask

  task automatic t_reset();
    int code;
    rst_n = 1'b0;
    set_cfg(1'b1, 11'd799, 7'd5, 2'd2);
    repeat (4) @(negedge clk);
    code = int'(cmp) + 2 * int'(cmp_n) + 4 * int'(wstart) + 8 * int'(wact)
         + 16 * int'(clp1_n) + 32 * int'(clp2_n);
    // R9: expected cmp=0 cmp_n=1 start=0 active=0 clamps=1 -> 2+16+32
    check(code == 50, "R9", "outputs held in reset", code, 50);
    rst_n = 1'b1;
    // R9: first line uses reset defaults, not the driven inputs
    measure_line(816, 75, 0, "R9");
  endtask

  task automatic t_vga_basic();
    set_cfg(1'b1, 11'd799, 7'd0, 2'd0);
    skip_line();
    measure_line(800, 110, 0, "R1");
  endtask

  task automatic t_vga_edge();
    // R5: window 237..880 clipped at dot 799
    set_cfg(1'b1, 11'd799, 7'd127, 2'd3);
    skip_line();
    measure_line(800, 237, 3, "R1");
  endtask

  task automatic t_vga_long();
    set_cfg(1'b1, 11'd1023, 7'd40, 2'd1);
    skip_line();
    measure_line(1024, 150, 1, "R1");
  endtask

  task automatic t_short_line();
    set_cfg(1'b1, 11'd255, 7'd0, 2'd2);
    skip_line();
    measure_line(256, 110, 2, "R1");
  endtask

  task automatic t_tv_fixed();
    // R2: divider input ignored in TV mode
    set_cfg(1'b0, 11'd500, 7'd20, 2'd2);
    skip_line();
    measure_line(816, 95, 2, "R2");
  endtask

  task automatic t_midline();
    // R8: change at dot 300 must not touch the running TV line
    n_vga = 1'b1; n_div = 11'd699; n_pos = 7'd64; n_sel = 2'd1;
    chg_at = 300;
    measure_line(816, 95, 2, "R8");
    measure_line(700, 174, 1, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_vga_basic();
    t_vga_edge();
    t_vga_long();
    t_short_line();
    t_tv_fixed();
    t_midline();
    finish_run();
  end

endmodule